// File: doc/BRIEF.md
# Constant-Gain Two-Axis Position Tracker

This block smooths a stream of noisy 2D position measurements with a constant-gain Kalman filter. It assumes each target moves at constant velocity. Each axis keeps a position estimate and a velocity estimate. For every measurement the block first predicts the new position from the elapsed time step, then corrects both estimates with the innovation. The innovation is the measurement minus the prediction, scaled by two fixed gains. The gains, the time step and the initial state are loaded at run time through a configuration strobe. The block never computes them.

Measurements enter a 512-word queue as packed 32-bit words. Each word holds the X and Y coordinates as signed Q8.7 numbers. Filtered positions leave through a second 512-word queue in the same packing. The core takes one queued measurement at most every third cycle. It takes none while the result queue is full, so a slow consumer stalls the filter instead of losing results.

Top module: `kft_tracker`

## Requirements
- R1: Input and output words carry the X coordinate in bits [15:0] and the Y coordinate in bits [31:16]. Each coordinate is a two's-complement Q8.7 value: 1 sign bit, 8 integer bits and 7 fraction bits.
- R2: For each axis independently, one measurement z is processed in two steps. The predict step computes pp = p + T·v. The update step computes r = z − pp, then p = pp + Kp·r and v = v + Kv·r. The output word holds the updated p of both axes.
- R3: Each product of two Q8.7 values is returned to Q8.7 by adding 2^6 to the full product and shifting it arithmetically right by 7 (round half up). For example, 0.5 times +1 LSB gives +1 LSB, and 0.5 times −1 LSB gives 0.
- R4: Every sum, difference and rounded product saturates to the range [−32768, 32767] instead of wrapping.
- R5: A configuration strobe latches Kp, Kv, T and the initial p and v of both axes, but only when no measurement is in flight. A strobe raised while a measurement is being processed is ignored. A strobe in an idle cycle wins over starting a new measurement.
- R6: Two measurement reads are always at least 3 cycles apart. With measurements waiting and room for results, filtered words arrive exactly 3 cycles apart.
- R7: While the result queue is full, no measurement is read and no result is written. Processing resumes once a result is removed.
- R8: Each queue holds 512 words. The measurement-queue full flag is high exactly when 512 words are waiting. A push into a full queue or a pop from an empty queue has no effect.
- R9: After reset both queues are empty and every gain and state value is zero, so a measurement processed before any load yields a zero result.
- R10: The position and velocity estimates change only through a load or an update. They carry from one measurement to the next, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_push_i | input | 1 | Push a measurement word |
| smp_data_i | input | 32 | Measurement word, Y in [31:16], X in [15:0] |
| smp_full_o | output | 1 | Measurement queue full |
| est_pop_i | input | 1 | Remove the head result word |
| est_data_o | output | 32 | Head result word, same packing |
| est_empty_o | output | 1 | Result queue empty |
| cfg_load_i | input | 1 | Configuration load strobe |
| cfg_gain_pos_i | input | 16 | Position gain Kp, Q8.7 |
| cfg_gain_vel_i | input | 16 | Velocity gain Kv, Q8.7 |
| cfg_dt_i | input | 16 | Time step T, Q8.7 |
| cfg_pos_x_i | input | 16 | Initial X position |
| cfg_pos_y_i | input | 16 | Initial Y position |
| cfg_vel_x_i | input | 16 | Initial X velocity |
| cfg_vel_y_i | input | 16 | Initial Y velocity |

## Verification
The assertions take for granted that the environment respects the queue flags, and that a configuration load is raised while the core is idle whenever the new values are meant to take effect. The stimulus pushes only while the full flag is low and pops only while the empty flag is low. It loads new gains only after every expected result has been drained, apart from one deliberate load raised during processing to show that it is ignored. The arithmetic sweep crosses a grid of gains and time steps with pseudo-random measurements that reach both saturation limits.

// File: rtl/kft_pkg.sv
package kft_pkg;
  localparam int QW   = 16;
  localparam int QF   = 7;
  localparam int AXES = 2;
  localparam int WW   = QW * AXES;
  localparam int QMAX = 2 ** (QW - 1) - 1;
  localparam int QMIN = -(2 ** (QW - 1));

  typedef logic signed [QW-1:0] q_t;
  typedef logic signed [2*QW:0] w_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PRED, ST_UPD} st_e;

  function automatic q_t q_sat(input w_t x);
    if (x > w_t'(QMAX)) return q_t'(QMAX);
    if (x < w_t'(QMIN)) return q_t'(QMIN);
    return x[QW-1:0];
  endfunction

  function automatic q_t q_add(input q_t a, input q_t b);
    return q_sat(w_t'(a) + w_t'(b));
  endfunction

  function automatic q_t q_sub(input q_t a, input q_t b);
    return q_sat(w_t'(a) - w_t'(b));
  endfunction

  // full product, add half LSB, arithmetic shift, clamp
  function automatic q_t q_mul(input q_t a, input q_t b);
    w_t p;
    p = w_t'(a) * w_t'(b);
    p = p + w_t'(2 ** (QF - 1));
    p = p >>> QF;
    return q_sat(p);
  endfunction
endpackage

// File: rtl/kft_fifo.sv
module kft_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   CNT_FULL = (AW + 1)'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_fifo_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  assert_fifo_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o);
  assert_fifo_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/kft_axis.sv
module kft_axis
  import kft_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  q_t   init_p_i,
  input  q_t   init_v_i,
  input  q_t   dt_i,
  input  q_t   k_pos_i,
  input  q_t   k_vel_i,
  input  q_t   z_i,
  input  logic pred_i,
  input  logic upd_i,
  output q_t   p_upd_o
);
  q_t p_q, v_q, pp_q;
  q_t pp_next, res, p_new, v_new;

  always_comb begin
    pp_next = q_add(p_q, q_mul(dt_i, v_q));
    res     = q_sub(z_i, pp_q);
    p_new   = q_add(pp_q, q_mul(k_pos_i, res));
    v_new   = q_add(v_q, q_mul(k_vel_i, res));
  end

  assign p_upd_o = p_new;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q  <= '0;
      v_q  <= '0;
      pp_q <= '0;
    end else if (ld_i) begin
      p_q <= init_p_i;
      v_q <= init_v_i;
    end else if (pred_i) begin
      pp_q <= pp_next;
    end else if (upd_i) begin
      p_q <= p_new;
      v_q <= v_new;
    end
  end

  assert_state_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !upd_i) |=> ($stable(p_q) && $stable(v_q)));
  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pred_i && upd_i));
endmodule

// File: rtl/kft_tracker.sv
module kft_tracker
  import kft_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_push_i,
  input  logic [WW-1:0] smp_data_i,
  output logic          smp_full_o,
  input  logic          est_pop_i,
  output logic [WW-1:0] est_data_o,
  output logic          est_empty_o,
  input  logic          cfg_load_i,
  input  logic [QW-1:0] cfg_gain_pos_i,
  input  logic [QW-1:0] cfg_gain_vel_i,
  input  logic [QW-1:0] cfg_dt_i,
  input  logic [QW-1:0] cfg_pos_x_i,
  input  logic [QW-1:0] cfg_pos_y_i,
  input  logic [QW-1:0] cfg_vel_x_i,
  input  logic [QW-1:0] cfg_vel_y_i
);
  st_e           st_q;
  logic          in_empty, in_pop, out_full, out_push;
  logic [WW-1:0] in_head, z_q, out_word;
  logic          ld, start, pred_en, upd_en;
  q_t            k_pos_q, k_vel_q, dt_q;
  q_t            init_p [AXES];
  q_t            init_v [AXES];
  q_t            p_upd  [AXES];

  kft_fifo #(.W(WW), .DEPTH(DEPTH)) u_in_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (smp_push_i),
    .data_i  (smp_data_i),
    .full_o  (smp_full_o),
    .pop_i   (in_pop),
    .data_o  (in_head),
    .empty_o (in_empty)
  );

  kft_fifo #(.W(WW), .DEPTH(DEPTH)) u_out_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (out_push),
    .data_i  (out_word),
    .full_o  (out_full),
    .pop_i   (est_pop_i),
    .data_o  (est_data_o),
    .empty_o (est_empty_o)
  );

  // load wins over a new start in an idle cycle
  assign ld       = cfg_load_i && (st_q == ST_IDLE);
  assign start    = (st_q == ST_IDLE) && !cfg_load_i && !in_empty && !out_full;
  assign in_pop   = start;
  assign pred_en  = (st_q == ST_PRED);
  assign upd_en   = (st_q == ST_UPD);
  assign out_push = upd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      z_q     <= '0;
      k_pos_q <= '0;
      k_vel_q <= '0;
      dt_q    <= '0;
    end else begin
      if (ld) begin
        k_pos_q <= cfg_gain_pos_i;
        k_vel_q <= cfg_gain_vel_i;
        dt_q    <= cfg_dt_i;
      end
      if (start) z_q <= in_head;
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_PRED;
        ST_PRED: st_q <= ST_UPD;
        ST_UPD:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    init_p[0] = cfg_pos_x_i;
    init_p[1] = cfg_pos_y_i;
    init_v[0] = cfg_vel_x_i;
    init_v[1] = cfg_vel_y_i;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    kft_axis u_axis (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld),
      .init_p_i (init_p[a]),
      .init_v_i (init_v[a]),
      .dt_i     (dt_q),
      .k_pos_i  (k_pos_q),
      .k_vel_i  (k_vel_q),
      .z_i      (z_q[a*QW +: QW]),
      .pred_i   (pred_en),
      .upd_i    (upd_en),
      .p_upd_o  (p_upd[a])
    );
    assign out_word[a*QW +: QW] = p_upd[a];
  end

  assert_read_pace_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pop |=> (!in_pop ##1 !in_pop));
  assert_stall_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pop |-> !out_full);
  assert_stall_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_push |-> !out_full);
  assert_cfg_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(k_pos_q) && $stable(k_vel_q) && $stable(dt_q)));
  assert_result_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pop |=> ##1 out_push);
endmodule

// File: tb/kft_tracker_test.sv
module kft_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_push = 1'b0;
  logic [31:0] smp_data = '0;
  logic        smp_full;
  logic        est_pop = 1'b0;
  logic [31:0] est_data;
  logic        est_empty;
  logic        cfg_load = 1'b0;
  logic [15:0] c_kp = '0, c_kv = '0, c_dt = '0, c_px = '0, c_py = '0, c_vx = '0, c_vy = '0;

  always #5 clk = ~clk;

  kft_tracker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_push_i(smp_push), .smp_data_i(smp_data), .smp_full_o(smp_full),
    .est_pop_i(est_pop), .est_data_o(est_data), .est_empty_o(est_empty),
    .cfg_load_i(cfg_load), .cfg_gain_pos_i(c_kp), .cfg_gain_vel_i(c_kv),
    .cfg_dt_i(c_dt), .cfg_pos_x_i(c_px), .cfg_pos_y_i(c_py),
    .cfg_vel_x_i(c_vx), .cfg_vel_y_i(c_vy)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] rs = 32'h1ace_b00c;
  int m_kp = 0, m_kv = 0, m_dt = 0;
  int m_p[2] = '{0, 0};
  int m_v[2] = '{0, 0};

  always @(posedge clk) cyc++;

  function automatic int sat(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  function automatic int rmul(int a, int b);
    longint p;
    p = longint'(a) * longint'(b) + 64;
    return sat(p >>> 7);
  endfunction

  function automatic int step(int ax, int z);
    int pp, r;
    pp = sat(longint'(m_p[ax]) + rmul(m_dt, m_v[ax]));
    r  = sat(longint'(z) - pp);
    m_p[ax] = sat(longint'(pp) + rmul(m_kp, r));
    m_v[ax] = sat(longint'(m_v[ax]) + rmul(m_kv, r));
    return m_p[ax];
  endfunction

  function automatic int rnd16();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return int'($signed(rs[15:0]));
  endfunction

  function automatic int lo(logic [31:0] w);
    return int'($signed(w[15:0]));
  endfunction

  function automatic int hi(logic [31:0] w);
    return int'($signed(w[31:16]));
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cfg(int kp, int kv, int dt, int px, int py, int vx, int vy);
    c_kp = 16'(kp); c_kv = 16'(kv); c_dt = 16'(dt);
    c_px = 16'(px); c_py = 16'(py); c_vx = 16'(vx); c_vy = 16'(vy);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_kp = kp; m_kv = kv; m_dt = dt;
    m_p[0] = px; m_p[1] = py; m_v[0] = vx; m_v[1] = vy;
  endtask

  task automatic push(int x, int y);
    int ex, ey;
    ex = step(0, x);
    ey = step(1, y);
    exp_q.push_back({ey[15:0], ex[15:0]});
    while (smp_full) begin
      smp_push = 1'b0;
      @(negedge clk);
    end
    smp_push = 1'b1;
    smp_data = {y[15:0], x[15:0]};
    @(negedge clk);
    smp_push = 1'b0;
  endtask

  task automatic pop_word(output logic [31:0] w);
    while (est_empty) @(negedge clk);
    w = est_data;
    est_pop = 1'b1;
    @(negedge clk);
    est_pop = 1'b0;
    if (exp_q.size() > 0) void'(exp_q.pop_front());
  endtask

  task automatic drain(int n, string req);
    logic [31:0] w, e;
    for (int i = 0; i < n; i++) begin
      while (est_empty) @(negedge clk);
      w = est_data;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hdead_beef;
      chk(lo(w) == lo(e), {req, " x"}, lo(w), lo(e));
      chk(hi(w) == hi(e), {req, " y"}, hi(w), hi(e));
      est_pop = 1'b1;
      @(negedge clk);
      est_pop = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w;
    int stamp[4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state and zero configuration
    chk(est_empty == 1'b1, "R9 est_empty", int'(est_empty), 1);
    chk(smp_full == 1'b0, "R9 smp_full", int'(smp_full), 0);
    push(100, -5);
    pop_word(w);
    chk(w == 32'h0, "R9 result", int'(w), 0);

    // R3: half-LSB products round upward
    cfg(0, 0, 64, 0, 0, 1, -1);
    push(0, 0);
    pop_word(w);
    chk(lo(w) == 1, "R3 x", lo(w), 1);
    chk(hi(w) == 0, "R3 y", hi(w), 0);

    // R4: saturation of the predict sum and the residual
    cfg(0, 0, 128, 32767, -32768, 32767, -32768);
    push(0, 0);
    pop_word(w);
    chk(lo(w) == 32767, "R4 x high", lo(w), 32767);
    chk(hi(w) == -32768, "R4 y low", hi(w), -32768);
    cfg(128, 0, 0, 32767, 0, 0, 0);
    push(-32768, 5);
    pop_word(w);
    chk(lo(w) == -1, "R4 residual", lo(w), -1);
    chk(hi(w) == 5, "R4 unit gain", hi(w), 5);

    // R1: unit gain and zero step pass the measurement through
    cfg(128, 0, 0, 0, 0, 0, 0);
    push(4660, -1383);
    pop_word(w);
    chk(int'(w[15:0]) == 4660, "R1 x field", int'(w[15:0]), 4660);
    chk(hi(w) == -1383, "R1 y field", hi(w), -1383);

    // R5: load strobe while busy is ignored
    cfg(64, 16, 128, 10, 20, 3, -4);
    push(40, -30);
    @(negedge clk);
    c_kp = 16'd0; c_kv = 16'd0; c_dt = 16'd0;
    c_px = 16'd999; c_py = 16'd999; c_vx = 16'd77; c_vy = 16'd77;
    cfg_load = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
    push(55, -41);
    push(70, -52);
    drain(3, "R5");

    // R6: three-cycle result spacing on a burst
    cfg(32, 8, 128, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) push(i * 100, -i * 50);
    for (int i = 0; i < 4; i++) begin
      while (est_empty) @(negedge clk);
      stamp[i] = cyc;
      pop_word(w);
    end
    for (int i = 1; i < 4; i++)
      chk(stamp[i] - stamp[i-1] == 3, "R6 spacing", stamp[i] - stamp[i-1], 3);

    // R2, R10: sweep over gains and time steps
    for (int ki = 0; ki < 5; ki++)
      for (int kv = 0; kv < 3; kv++)
        for (int d = 0; d < 3; d++) begin
          cfg(ki * 32, kv * 20, 64 << d, rnd16() >>> 3, rnd16() >>> 3,
              rnd16() >>> 6, rnd16() >>> 6);
          for (int s = 0; s < 6; s++) push(rnd16(), rnd16() >>> 2);
          drain(6, "R2,R10");
        end

    // R7, R8: full result queue stalls reading
    cfg(64, 16, 128, 0, 0, 0, 0);
    for (int i = 0; i < 1024; i++) push(rnd16() >>> 4, rnd16() >>> 4);
    repeat (20) @(negedge clk);
    chk(smp_full == 1'b1, "R8 input full", int'(smp_full), 1);
    repeat (30) @(negedge clk);
    chk(smp_full == 1'b1, "R7 no read while full", int'(smp_full), 1);
    chk(est_empty == 1'b0, "R7 results held", int'(est_empty), 0);
    drain(1024, "R7");
    repeat (10) @(negedge clk);
    chk(est_empty == 1'b1, "R8 drained", int'(est_empty), 1);
    chk(exp_q.size() == 0, "R8 count", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule